// File: doc/BRIEF.md
# Modem Control Register

This block holds the host-writable control byte of a 16550-style serial port's modem section. Each defined bit drives one active-low modem pin, or steers the port's interrupt line. A host write takes effect at the next clock edge. The pins follow the stored bits with inverted polarity: a stored 1 pulls the matching pin low.

One bit has two jobs. It drives the general-purpose output OP2# low, and it also releases the interrupt line from high impedance. A second bit switches the port into internal loopback. In loopback the external pins are parked at their idle high level. The stored bits are then presented, active high, to the modem status logic in place of the real DSR, CTS, RI and CD inputs. The bit that has no pin of its own becomes the ring-indicator source, but only during loopback. A companion flow-control engine can take over the request-to-send pin when automatic flow control is enabled.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the stored byte reads 0x00. `dtr_n_o`, `rts_n_o` and `op2_n_o` are 1, and `irq_oe`, `loop_en` and all four loopback status outputs are 0.
- R2: Bit 0 of the stored byte controls DTR#. Outside loopback, `dtr_n_o` is 0 when bit 0 is 1 and 1 when bit 0 is 0.
- R3: Bit 1 controls RTS#. Outside loopback and with `auto_flow_en` at 0, `rts_n_o` is the inverse of bit 1.
- R4: With `auto_flow_en` at 1 and outside loopback, `rts_n_o` is the inverse of `flow_rts_req` and does not depend on bit 1.
- R5: Bit 3 controls both the interrupt line and OP2#. When bit 3 is 1, `irq_oe` is 1 and, outside loopback, `op2_n_o` is 0. When bit 3 is 0, `irq_oe` is 0 and `op2_n_o` is 1.
- R6: Bit 4 selects loopback and appears on `loop_en`. While it is 1, `dtr_n_o`, `rts_n_o` and `op2_n_o` are all 1, whatever the other bits and `flow_rts_req` are.
- R7: In loopback, `lb_dsr`, `lb_cts`, `lb_ri` and `lb_cd` equal stored bits 0, 1, 2 and 3 respectively. Outside loopback all four are 0. Bit 2 has no effect on any pin.
- R8: `rd_data[4:0]` returns the last written bits 4:0. `rd_data[7:5]` always reads 0, and writing ones to bits 7:5 changes no output.
- R9: While `wr_en` is 0, the stored byte and every output derived from it hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Byte to store |
| rd_data | output | 8 | Stored byte as seen by the host |
| auto_flow_en | input | 1 | Hands RTS# to the flow-control engine |
| flow_rts_req | input | 1 | Flow-control engine asks for RTS asserted |
| dtr_n_o | output | 1 | DTR# pin, active low |
| rts_n_o | output | 1 | RTS# pin, active low |
| op2_n_o | output | 1 | OP2# general-purpose pin, active low |
| irq_oe | output | 1 | Output enable for the interrupt line |
| loop_en | output | 1 | Internal loopback selected |
| lb_dsr | output | 1 | Loopback DSR to modem status logic |
| lb_cts | output | 1 | Loopback CTS to modem status logic |
| lb_ri | output | 1 | Loopback RI to modem status logic |
| lb_cd | output | 1 | Loopback CD to modem status logic |

## Verification
Each write is captured at one rising edge. From then on every pin, every loopback status output and the read port are pure logic of the stored byte, so all of them are due one edge after the write strobe. The flow-control path has no register, so `rts_n_o` responds to `flow_rts_req` in the same cycle. The bench changes inputs on falling edges and checks at the next falling edge, after the single capture edge has passed. Combinational responses are checked at the falling edge right after the input change.

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl #(
  parameter int DATA_W = 8,
  parameter int USED_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              auto_flow_en,
  input  logic              flow_rts_req,
  output logic              dtr_n_o,
  output logic              rts_n_o,
  output logic              op2_n_o,
  output logic              irq_oe,
  output logic              loop_en,
  output logic              lb_dsr,
  output logic              lb_cts,
  output logic              lb_ri,
  output logic              lb_cd
);

  localparam int PAD_W = DATA_W - USED_W;

  logic [USED_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= wr_data[USED_W-1:0];
  end

  logic dtr_on, rts_on, ri_on, op2_on;
  assign dtr_on  = ctl_q[0];
  assign rts_on  = ctl_q[1];
  assign ri_on   = ctl_q[2];
  assign op2_on  = ctl_q[3];
  assign loop_en = ctl_q[4];

  logic rts_drive;
  assign rts_drive = auto_flow_en ? flow_rts_req : rts_on;

  assign dtr_n_o = loop_en | ~dtr_on;
  assign rts_n_o = loop_en | ~rts_drive;
  assign op2_n_o = loop_en | ~op2_on;
  assign irq_oe  = op2_on;

  assign lb_dsr = loop_en & dtr_on;
  assign lb_cts = loop_en & rts_on;
  assign lb_ri  = loop_en & ri_on;
  assign lb_cd  = loop_en & op2_on;

  assign rd_data = {{PAD_W{1'b0}}, ctl_q};

  assert_dtr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> dtr_n_o == !($past(wr_data[0]) && !$past(wr_data[4])));

  assert_irq_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> irq_oe == $past(wr_data[3]));

  assert_pins_idle_loop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (dtr_n_o && rts_n_o && op2_n_o));

  assert_lb_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> $countones({lb_dsr, lb_cts, lb_ri, lb_cd}) == 0);

  assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[DATA_W-1:USED_W] != '0) |=> rd_data[DATA_W-1:USED_W] == '0);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data) && $stable(irq_oe) && $stable(dtr_n_o));

  assert_flow_rts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_flow_en && !loop_en) |-> rts_n_o == !flow_rts_req);

endmodule

// File: tb/uart_modem_ctl_tb_top.sv
module uart_modem_ctl_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, auto_flow_en = 0, flow_rts_req = 0;
  logic [7:0] wr_data = '0, rd_data;
  logic dtr_n_o, rts_n_o, op2_n_o, irq_oe, loop_en, lb_dsr, lb_cts, lb_ri, lb_cd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_modem_ctl dut_i (.clk, .rst_n, .wr_en, .wr_data, .rd_data, .auto_flow_en,
    .flow_rts_req, .dtr_n_o, .rts_n_o, .op2_n_o, .irq_oe, .loop_en,
    .lb_dsr, .lb_cts, .lb_ri, .lb_cd);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic pins(string req, logic [2:0] exp);
    chk(req, {5'b0, dtr_n_o, rts_n_o, op2_n_o}, {5'b0, exp});
  endtask

  task automatic lbs(string req, logic [3:0] exp);
    chk(req, {4'b0, lb_cd, lb_ri, lb_cts, lb_dsr}, {4'b0, exp});
  endtask

  task automatic t_reset_R1;
    chk("R1 read", rd_data, 8'h00);
    pins("R1 pins", 3'b111);
    chk("R1 irq/loop", {6'b0, irq_oe, loop_en}, 8'h00);
    lbs("R1 loopback outs", 4'b0000);
  endtask

  task automatic t_dtr_R2;
    wr(8'h01); pins("R2 dtr low", 3'b011);
    wr(8'h00); pins("R2 dtr high", 3'b111);
  endtask

  task automatic t_rts_R3;
    wr(8'h02); pins("R3 rts low", 3'b101);
    wr(8'h00); pins("R3 rts high", 3'b111);
  endtask

  task automatic t_flow_R4;
    wr(8'h02);
    @(negedge clk); auto_flow_en = 1; flow_rts_req = 0;
    #1 pins("R4 flow overrides bit1", 3'b111);
    @(negedge clk); flow_rts_req = 1;
    #1 pins("R4 flow asserts rts", 3'b101);
    wr(8'h00);
    pins("R4 flow ignores bit1 clear", 3'b101);
    @(negedge clk); auto_flow_en = 0; flow_rts_req = 0;
    #1 pins("R4 released", 3'b111);
  endtask

  task automatic t_op2_R5;
    wr(8'h08);
    pins("R5 op2 low", 3'b110);
    chk("R5 irq enabled", {7'b0, irq_oe}, 8'h01);
    wr(8'h00);
    chk("R5 irq disabled", {7'b0, irq_oe}, 8'h00);
    pins("R5 op2 high", 3'b111);
  endtask

  task automatic t_loop_R6_R7;
    wr(8'h1F);
    chk("R6 loop_en", {7'b0, loop_en}, 8'h01);
    pins("R6 pins idle", 3'b111);
    chk("R5 irq in loop", {7'b0, irq_oe}, 8'h01);
    lbs("R7 all mapped", 4'b1111);
    @(negedge clk); auto_flow_en = 1; flow_rts_req = 1;
    #1 pins("R6 flow blocked in loop", 3'b111);
    @(negedge clk); auto_flow_en = 0; flow_rts_req = 0;
    wr(8'h15); lbs("R7 dsr+ri", 4'b0101);
    wr(8'h1A); lbs("R7 cts+cd", 4'b1010);
    wr(8'h04); lbs("R7 ri no effect outside loop", 4'b0000);
    pins("R7 bit2 no pin", 3'b111);
    wr(8'h00);
  endtask

  task automatic t_read_R8;
    wr(8'hE0);
    chk("R8 reserved read zero", rd_data, 8'h00);
    pins("R8 reserved no pin effect", 3'b111);
    lbs("R8 reserved no loop effect", 4'b0000);
    wr(8'hEB);
    chk("R8 readback", rd_data, 8'h0B);
  endtask

  task automatic t_hold_R9;
    wr(8'h09);
    @(negedge clk); wr_data = 8'h16;
    repeat (3) @(negedge clk);
    chk("R9 hold read", rd_data, 8'h09);
    pins("R9 hold pins", 3'b010);
    wr_data = '0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset_R1();
    rst_n = 1;
    @(negedge clk);
    t_dtr_R2();
    t_rts_R3();
    t_flow_R4();
    t_op2_R5();
    t_loop_R6_R7();
    t_read_R8();
    t_hold_R9();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule